// File: doc/BRIEF.md
# Phase-Frequency Detector with Lock Indicator

This block compares two single-cycle event streams, a divided reference event and a divided feedback event, both synchronous to the reference oscillator clock. It measures which of the two arrives first and by how many oscillator cycles. While one side leads, the block drives a tri-state pump request. It also drives a push-pull comparator line and an open-drain pull-down line. The sense of all three is reversed by a polarity select.

A lock indicator is built from the same measurement. Lock is lost as soon as the running phase error reaches an unlock window. Lock is regained only after a set number of consecutive comparisons whose error stays within a tighter lock window. Both windows are parameters counted in oscillator cycles.

A monitor output carries either the lock indicator or one of the two divided event streams. A pump enable input can force the pump line undriven. A run input selects normal operation or power save. In power save the pump and comparator lines are idle and lock reads high. The first comparison after leaving power save is not passed to the pump and does not change the lock state. A charge-pump current select bit is passed straight through.

Top module: `pfd_lock_detector`

## Requirements
- R1: With `pol_sel`=1, a reference event that precedes the feedback event by d cycles gives `pump_oe`=1 with `pump_val`=1 for exactly d cycles. A feedback event that leads by d cycles gives `pump_oe`=1 with `pump_val`=0 for d cycles. The drive starts in the cycle after the leading event.
- R2: With `pol_sel`=0 the value on `pump_val` is inverted for both leading cases: 0 while the reference leads and 1 while the feedback leads.
- R3: Reference and feedback events in the same cycle produce no pump drive (`pump_oe` stays 0).
- R4: With `pol_sel`=1, `cmp_cmos` is 1 only while the feedback leads, and `cmp_od_pull` is 1 only while the reference leads. With `pol_sel`=0 these two roles are swapped between the leading sides.
- R5: In the cycle after the running phase error reaches `TWU` cycles (default 3), `lock_out` is 0.
- R6: `lock_out` becomes 1 in the cycle after the `LOCK_CYC`-th (default 3) consecutive comparison with an error of at most `TWL` cycles (default 2). A comparison with a larger error restarts the count.
- R7: `mon_out` equals `lock_out` when `mon_sel`=0. When `mon_sel`=1 it equals `ref_evt` if `pol_sel`=1 and `fb_evt` if `pol_sel`=0.
- R8: While `pump_en`=0, `pump_oe` is 0 and the comparator lines keep working.
- R9: While `run_en`=0, the pump and comparator lines are idle, any pending comparison is dropped, and `lock_out` is 1.
- R10: After `run_en` returns to 1, the first completed comparison produces no pump or comparator activity and leaves `lock_out` unchanged.
- R11: `cur_sel_o` always equals `cur_sel_i`.
- R12: During and after reset with no events, `pump_oe`, `lock_out`, `cmp_cmos` and `cmp_od_pull` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | Reference oscillator clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_evt | input | 1 | Divided reference event, one cycle wide |
| fb_evt | input | 1 | Divided feedback event, one cycle wide |
| pol_sel | input | 1 | Output polarity select |
| mon_sel | input | 1 | Monitor select: 0 lock, 1 divided event |
| pump_en | input | 1 | 0 forces the pump line undriven |
| run_en | input | 1 | 1 normal operation, 0 power save |
| cur_sel_i | input | 1 | Pump current select bit in |
| pump_oe | output | 1 | Pump line driven |
| pump_val | output | 1 | Pump line level when driven |
| cmp_cmos | output | 1 | Push-pull comparator line |
| cmp_od_pull | output | 1 | Open-drain line pulls low when 1 |
| mon_out | output | 1 | Monitor output |
| lock_out | output | 1 | Lock indicator |
| cur_sel_o | output | 1 | Pump current select bit out |

## Verification
A scripted sequence first applies coincident events, then small and large offsets, then swaps polarity, to separate the three comparator states and the asymmetric lock and unlock windows. Random offsets from -4 to +4 cycles fall into three bands: within the lock window, between the windows, and at or beyond the unlock window. This shows whether the error is counted to the right cycle and whether the consecutive-comparison count is restarted. Random toggling of polarity, monitor select, pump enable and power save shows that each gate acts only on its own outputs. Each power-save exit tests that the first comparison is discarded.

// File: rtl/pfdl_pkg.sv
package pfdl_pkg;
   // Which event is waiting for its partner.
   typedef enum logic [1:0] {
      LEAD_NONE = 2'd0,
      LEAD_REF  = 2'd1,
      LEAD_FB   = 2'd2
   } lead_e;
endpackage

// File: rtl/pfdl_edge_arbiter.sv
module pfdl_edge_arbiter
   import pfdl_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  run_en,
   input  logic  ref_evt,
   input  logic  fb_evt,
   output lead_e lead_q,
   output logic  done
);
   lead_e lead_d;

   // A comparison completes when the missing side arrives.
   always_comb begin
      unique case (lead_q)
         LEAD_REF: done = fb_evt;
         LEAD_FB:  done = ref_evt;
         default:  done = ref_evt & fb_evt;
      endcase
   end

   always_comb begin
      lead_d = lead_q;
      if (!run_en || done) begin
         lead_d = LEAD_NONE;
      end else if (lead_q == LEAD_NONE) begin
         if (ref_evt)     lead_d = LEAD_REF;
         else if (fb_evt) lead_d = LEAD_FB;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) lead_q <= LEAD_NONE;
      else        lead_q <= lead_d;
   end

   a_r9_sleep_drops_pending: assert property (@(posedge clk) disable iff (!rst_n)
      !run_en |=> (lead_q == LEAD_NONE));
   a_r3_match_stays_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (lead_q == LEAD_NONE && ref_evt && fb_evt) |=> (lead_q == LEAD_NONE));
   a_r1_no_illegal_state: assert property (@(posedge clk) disable iff (!rst_n)
      lead_q != 2'd3);
endmodule

// File: rtl/pfdl_lock_meter.sv
module pfdl_lock_meter #(
   parameter int TWU      = 3,
   parameter int TWL      = 2,
   parameter int LOCK_CYC = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_en,
   input  logic active,
   input  logic done,
   output logic lock_q,
   output logic skip_q
);
   localparam int ERR_W = $clog2(TWU + 1);
   localparam int CNT_W = $clog2(LOCK_CYC + 1);
   localparam logic [ERR_W-1:0] ERR_MAX = ERR_W'(TWU);
   localparam logic [ERR_W:0]   UNLK_V  = (ERR_W+1)'(TWU);
   localparam logic [ERR_W:0]   LOCK_V  = (ERR_W+1)'(TWL);
   localparam logic [CNT_W-1:0] GOOD_V  = CNT_W'(LOCK_CYC);

   logic [ERR_W-1:0] err_q;
   logic [CNT_W-1:0] good_q, good_inc;
   logic [ERR_W:0]   run_raw, run_err;
   logic             too_far, small_err;

   // Error so far, in oscillator cycles, including the present cycle.
   assign run_raw   = {1'b0, err_q} + (ERR_W+1)'(active);
   assign run_err   = (run_raw > UNLK_V) ? UNLK_V : run_raw;
   assign too_far   = active && (run_err >= UNLK_V);
   assign small_err = (run_err <= LOCK_V);
   assign good_inc  = (good_q == GOOD_V) ? good_q : good_q + 1'b1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         err_q  <= '0;
         good_q <= '0;
         lock_q <= 1'b0;
         skip_q <= 1'b0;
      end else if (!run_en) begin
         err_q  <= '0;
         good_q <= '0;
         lock_q <= 1'b1;
         skip_q <= 1'b1;
      end else begin
         if (done || !active)        err_q <= '0;
         else if (err_q != ERR_MAX)  err_q <= err_q + 1'b1;

         if (skip_q) begin
            if (done) skip_q <= 1'b0;
         end else if (too_far) begin
            lock_q <= 1'b0;
            good_q <= '0;
         end else if (done) begin
            if (small_err) begin
               good_q <= good_inc;
               if (good_inc == GOOD_V) lock_q <= 1'b1;
            end else begin
               good_q <= '0;
            end
         end
      end
   end

   a_r5_unlock_next: assert property (@(posedge clk) disable iff (!rst_n)
      (run_en && !skip_q && too_far) |=> !lock_q);
   a_r6_rise_on_compare: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(lock_q) && $past(run_en)) |-> $past(done && small_err));
   a_r9_sleep_lock_high: assert property (@(posedge clk) disable iff (!rst_n)
      !run_en |=> lock_q);
   a_r10_first_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (run_en && skip_q && done) |=> ($stable(lock_q) && !skip_q));
   a_r5_err_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      err_q <= ERR_MAX);
endmodule

// File: rtl/pfdl_out_map.sv
module pfdl_out_map
   import pfdl_pkg::*;
#(
   parameter bit PUMP_REG = 1'b0
) (
   input  logic  clk,
   input  logic  rst_n,
   input  lead_e lead_q,
   input  logic  visible,
   input  logic  pol_sel,
   input  logic  pump_en,
   output logic  pump_oe,
   output logic  pump_val,
   output logic  cmp_cmos,
   output logic  cmp_od_pull
);
   logic up, dn;
   logic oe_c, val_c, cmos_c, od_c;

   assign up     = visible && (lead_q == LEAD_REF);
   assign dn     = visible && (lead_q == LEAD_FB);
   assign oe_c   = pump_en && (up || dn);
   assign val_c  = pol_sel ? up : dn;
   assign cmos_c = pol_sel ? dn : up;
   assign od_c   = pol_sel ? up : dn;

   generate
      if (PUMP_REG) begin : g_reg
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               pump_oe     <= 1'b0;
               pump_val    <= 1'b0;
               cmp_cmos    <= 1'b0;
               cmp_od_pull <= 1'b0;
            end else begin
               pump_oe     <= oe_c;
               pump_val    <= val_c;
               cmp_cmos    <= cmos_c;
               cmp_od_pull <= od_c;
            end
         end
      end else begin : g_comb
         assign pump_oe     = oe_c;
         assign pump_val    = val_c;
         assign cmp_cmos    = cmos_c;
         assign cmp_od_pull = od_c;

         a_r8_disable_holds: assert property (@(posedge clk) disable iff (!rst_n)
            !pump_en |-> !pump_oe);
         a_r1_drive_needs_lead: assert property (@(posedge clk) disable iff (!rst_n)
            pump_oe |-> (lead_q != LEAD_NONE));
         a_r4_lines_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
            !(cmp_cmos && cmp_od_pull));
      end
   endgenerate
endmodule

// File: rtl/pfd_lock_detector.sv
module pfd_lock_detector
   import pfdl_pkg::*;
#(
   parameter int TWU      = 3,
   parameter int TWL      = 2,
   parameter int LOCK_CYC = 3,
   parameter bit PUMP_REG = 1'b0
) (
   input  logic clk_osc,
   input  logic rst_n,
   input  logic ref_evt,
   input  logic fb_evt,
   input  logic pol_sel,
   input  logic mon_sel,
   input  logic pump_en,
   input  logic run_en,
   input  logic cur_sel_i,
   output logic pump_oe,
   output logic pump_val,
   output logic cmp_cmos,
   output logic cmp_od_pull,
   output logic mon_out,
   output logic lock_out,
   output logic cur_sel_o
);
   generate
      if (TWU < 2)       begin : g_bad_twu  $error("TWU must be at least 2");   end
      if (TWL >= TWU)    begin : g_bad_twl  $error("TWL must be below TWU");    end
      if (LOCK_CYC < 1)  begin : g_bad_cyc  $error("LOCK_CYC must be >= 1");    end
   endgenerate

   lead_e lead_q;
   logic  done, lock_q, skip_q, visible;

   pfdl_edge_arbiter u_arb (
      .clk     (clk_osc),
      .rst_n   (rst_n),
      .run_en  (run_en),
      .ref_evt (ref_evt),
      .fb_evt  (fb_evt),
      .lead_q  (lead_q),
      .done    (done)
   );

   pfdl_lock_meter #(
      .TWU      (TWU),
      .TWL      (TWL),
      .LOCK_CYC (LOCK_CYC)
   ) u_lock (
      .clk     (clk_osc),
      .rst_n   (rst_n),
      .run_en  (run_en),
      .active  (lead_q != LEAD_NONE),
      .done    (done),
      .lock_q  (lock_q),
      .skip_q  (skip_q)
   );

   assign visible = run_en && !skip_q;

   pfdl_out_map #(
      .PUMP_REG (PUMP_REG)
   ) u_map (
      .clk         (clk_osc),
      .rst_n       (rst_n),
      .lead_q      (lead_q),
      .visible     (visible),
      .pol_sel     (pol_sel),
      .pump_en     (pump_en),
      .pump_oe     (pump_oe),
      .pump_val    (pump_val),
      .cmp_cmos    (cmp_cmos),
      .cmp_od_pull (cmp_od_pull)
   );

   assign lock_out  = run_en ? lock_q : 1'b1;
   assign mon_out   = mon_sel ? (pol_sel ? ref_evt : fb_evt) : lock_out;
   assign cur_sel_o = cur_sel_i;

   a_r10_quiet_after_wake: assert property (@(posedge clk_osc) disable iff (!rst_n)
      ($rose(run_en)) |-> (!pump_oe && !cmp_cmos && !cmp_od_pull));
endmodule

// File: tb/pfd_lock_detector_tb_top.sv
module pfd_lock_detector_tb_top;
   localparam int TWU = 3;
   localparam int TWL = 2;
   localparam int NC  = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ref_evt = 0, fb_evt = 0, pol_sel = 1, mon_sel = 0;
   logic pump_en = 1, run_en = 1, cur_sel_i = 0;
   logic pump_oe, pump_val, cmp_cmos, cmp_od_pull, mon_out, lock_out, cur_sel_o;

   int n_checks = 0;
   int n_errors = 0;
   bit done_flag = 0;

   // model state
   int m_pend = 0;   // 0 none, 1 reference ahead, 2 feedback ahead
   int m_age = 0, m_good = 0;
   bit m_lock = 0, m_skip = 0;
   bit saw_oe, saw_od;

   always #10 clk = ~clk;

   pfd_lock_detector dut_i (
      .clk_osc(clk), .rst_n(rst_n), .ref_evt(ref_evt), .fb_evt(fb_evt),
      .pol_sel(pol_sel), .mon_sel(mon_sel), .pump_en(pump_en), .run_en(run_en),
      .cur_sel_i(cur_sel_i), .pump_oe(pump_oe), .pump_val(pump_val),
      .cmp_cmos(cmp_cmos), .cmp_od_pull(cmp_od_pull), .mon_out(mon_out),
      .lock_out(lock_out), .cur_sel_o(cur_sel_o)
   );

   task automatic chk(input string tag, input logic act, input logic exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s: got %0b expected %0b at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic bit exp_lock();
      return run_en ? m_lock : 1'b1;
   endfunction

   task automatic compare();
      bit up, dn, oe;
      string ptag;
      up = run_en && !m_skip && (m_pend == 1);
      dn = run_en && !m_skip && (m_pend == 2);
      oe = pump_en && (up || dn);
      if (!run_en)           ptag = "R9";
      else if (m_skip)       ptag = "R10";
      else if (!pump_en)     ptag = "R8";
      else if (!up && !dn)   ptag = "R3";
      else if (pol_sel)      ptag = "R1";
      else                   ptag = "R2";
      chk(ptag, pump_oe, oe);
      if (oe) chk(ptag, pump_val, pol_sel ? up : dn);
      chk("R4", cmp_cmos, pol_sel ? dn : up);
      chk("R4", cmp_od_pull, pol_sel ? up : dn);
      chk(!run_en ? "R9" : (m_lock ? "R6" : "R5"), lock_out, exp_lock());
      chk("R7", mon_out, mon_sel ? (pol_sel ? ref_evt : fb_evt) : exp_lock());
      chk("R11", cur_sel_o, cur_sel_i);
      saw_oe |= pump_oe;
      saw_od |= cmp_od_pull;
   endtask

   task automatic model_edge(input bit fr, input bit fp);
      int run;
      bit act, fin, old_skip;
      if (!run_en) begin
         m_pend = 0; m_age = 0; m_good = 0; m_lock = 1; m_skip = 1;
         return;
      end
      act = (m_pend != 0);
      run = m_age + (act ? 1 : 0);
      if (run > TWU) run = TWU;
      fin = (m_pend == 1 && fp) || (m_pend == 2 && fr) || (m_pend == 0 && fr && fp);
      old_skip = m_skip;
      if (fin) begin
         if (old_skip) m_skip = 0;
         else if (run <= TWL) begin
            if (m_good < NC) m_good++;
            if (m_good == NC) m_lock = 1;
         end else m_good = 0;
         m_pend = 0; m_age = 0;
      end else begin
         if (m_pend == 0) m_pend = fr ? 1 : (fp ? 2 : 0);
         m_age = act ? ((m_age < TWU) ? m_age + 1 : TWU) : 0;
      end
      if (!old_skip && act && run >= TWU) begin
         m_lock = 0; m_good = 0;
      end
   endtask

   task automatic step(input bit fr, input bit fp);
      @(negedge clk);
      ref_evt = fr; fb_evt = fp;
      #1 compare();
      @(posedge clk);
      #1 model_edge(fr, fp);
   endtask

   // one comparison period; off > 0 means reference first
   task automatic period(input int off);
      saw_oe = 0; saw_od = 0;
      for (int c = 0; c < 10; c++) step(c == 4, c == 4 + off);
   endtask

   initial begin
      void'($urandom(32'd24681));
      repeat (3) @(posedge clk);
      @(negedge clk); #1;
      chk("R12", pump_oe, 1'b0);
      chk("R12", lock_out, 1'b0);
      chk("R12", cmp_cmos, 1'b0);
      chk("R12", cmp_od_pull, 1'b0);
      rst_n = 1'b1;
      @(posedge clk); #1;

      // R3: coincident events
      period(0);
      chk("R3", saw_oe, 1'b0);
      // R6: two more small-error comparisons reach three in a row
      period(1);
      chk("R6", lock_out, 1'b0);
      period(2);
      chk("R6", lock_out, 1'b1);
      // R5: error of TWU cycles drops lock
      period(3);
      chk("R5", lock_out, 1'b0);
      // R2: reversed polarity, feedback first
      pol_sel = 0;
      period(-1);
      pol_sel = 1;
      // R8: pump disabled, comparator still active
      pump_en = 0;
      period(2);
      chk("R8", saw_oe, 1'b0);
      chk("R8", saw_od, 1'b1);
      pump_en = 1;
      // R9: power save
      run_en = 0;
      period(1);
      chk("R9", lock_out, 1'b1);
      chk("R9", saw_oe, 1'b0);
      // R10: first comparison after wake is discarded
      run_en = 1;
      period(3);
      chk("R10", saw_oe, 1'b0);
      chk("R10", lock_out, 1'b1);
      period(3);
      chk("R5", lock_out, 1'b0);

      // random phase offsets
      for (int p = 0; p < 300; p++) begin
         int off;
         if (p % 20 == 0) pol_sel = 1'($urandom % 2);
         mon_sel   = (($urandom % 4) == 0);
         pump_en   = (($urandom % 8) != 0);
         cur_sel_i = 1'($urandom % 2);
         run_en    = !((p % 37) >= 34);
         if (($urandom % 10) < 7) off = int'($urandom % 5) - 2;
         else                     off = int'($urandom % 9) - 4;
         period(off);
      end
      done_flag = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done_flag) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   end
endmodule